// File: doc/BRIEF.md
# Byte-to-Word Double-Buffered Host Bridge

This block links an 8-bit host processor to a 24-bit signal processor core. To the host it behaves like a small static memory with eight byte locations, selected by a 3-bit address and an active-low enable. To the core it appears as three memory-mapped words. The host sends a 24-bit word as three bytes: high, middle and low. The core receives that word whole, and the reverse direction works the same way. Each direction keeps two stages. A transmit side collects the data while a receive side holds the word that was last committed. Full/empty flags on the two sides are coupled to each other.

The host enable is asynchronous. It passes through a synchronizer chain into the core clock, and its two edges mark the start and the end of each host access. The start of a write stores the byte. The end of a read of the low byte releases the word. The host must hold the address, the read/write line and the write data stable for as long as the enable is low. A soft reset input puts the bridge back into the same state as the hardware reset.

Top module: `hb_bridge`

## Requirements
- R1: After reset the core status word (core offset 1) reads 0x02, with bit 0 receive-full = 0 and bit 1 transmit-empty = 1. The core control word (offset 0) reads 0. Host status (host address 2) reads 0x02: bit 0 is host-receive-full and bit 1 is host-transmit-empty. `d_irq` and `h_req` are low.
- R2: Host writes to addresses 5 (high), 6 (middle) and 7 (low) stage the bytes. The write to 7 commits {high, middle, low} as the core receive word at offset 3 and sets core status bit 0.
- R3: A core read of offset 3 returns the committed word and clears core status bit 0, which sets host status bit 1 again.
- R4: A host write to address 7 while core status bit 0 is set is ignored, and the core receive word keeps its previous value.
- R5: A core write to offset 3 while core status bit 1 is set loads the word for the host. Host reads of 5, 6 and 7 then return bits 23:16, 15:8 and 7:0 of that word. Core status bit 1 clears and host status bit 0 sets.
- R6: Only the end of a host read of address 7 sets core status bit 1 again. Reads of addresses 5 and 6 leave it clear.
- R7: A core write to offset 3 while core status bit 1 is clear is ignored, and the host keeps reading the earlier word.
- R8: `d_irq` is high exactly when (control bit 0 and status bit 0), (control bit 1 and status bit 1), or (control bit 2 and status bit 2) are both set.
- R9: Core control bits 4:3 appear as host status bits 4:3. Host control (address 0) bits 4:3 appear as core status bits 4:3. Core status bit 2 mirrors bit 7 of host address 1. Core status bit 7 is set when host control bits 6:5 are nonzero.
- R10: `h_req` is high exactly when (host control bit 0 and host status bit 0) or (host control bit 1 and host status bit 1).
- R11: A one-cycle `soft_rst` returns every register and flag to the R1 state.
- R12: Host addresses 0, 1 and 3 read back the byte last written to them. Address 4 reads 0. A host write to address 2 has no effect on what address 2 reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low hardware reset |
| soft_rst | input | 1 | Synchronous software reset |
| h_en_n | input | 1 | Host access enable, active low, asynchronous |
| h_rw | input | 1 | Host direction, 1 = read |
| h_addr | input | 3 | Host byte address |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data |
| h_req | output | 1 | Host service request |
| d_sel | input | 1 | Core access strobe (one cycle per access) |
| d_we | input | 1 | Core write enable |
| d_addr | input | 2 | Core word offset (0 control, 1 status, 3 data) |
| d_wdata | input | 24 | Core write data |
| d_rdata | output | 24 | Core read data |
| d_irq | output | 1 | Core interrupt request |

## Verification
Directed words with distinct high, middle and low bytes are used to catch any byte swap or misplaced byte in either direction. Back-to-back writes while the far side is still full tell a correctly blocked update apart from an overwrite. Reads of the high and middle bytes alone are used to confirm that only the low-byte read releases a word. Random words, sent in a random order of directions, show whether the two paths stay independent over many handoffs. The flag, command and mode bits are toggled one at a time so that each can be traced to the one status position it should reach.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 3 * BYTE_W;

  typedef enum logic [2:0] {
    HA_CTRL = 3'd0, HA_CMDV = 3'd1, HA_STAT = 3'd2, HA_VECT = 3'd3,
    HA_GAP  = 3'd4, HA_HI   = 3'd5, HA_MID  = 3'd6, HA_LO   = 3'd7
  } host_addr_e;

  typedef enum logic [1:0] {
    DA_CTRL = 2'd0, DA_STAT = 2'd1, DA_RSV = 2'd2, DA_DATA = 2'd3
  } dsp_addr_e;

  function automatic logic [WORD_W-1:0] join_bytes(
    input logic [BYTE_W-1:0] hi, input logic [BYTE_W-1:0] mid,
    input logic [BYTE_W-1:0] lo);
    return {hi, mid, lo};
  endfunction

  // sel: 0 high, 1 middle, 2 low
  function automatic logic [BYTE_W-1:0] pick_byte(
    input logic [WORD_W-1:0] w, input logic [1:0] sel);
    case (sel)
      2'd0:    return w[23:16];
      2'd1:    return w[15:8];
      default: return w[7:0];
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] dsp_status(
    input logic rx_full, input logic tx_empty, input logic cmd,
    input logic [1:0] hflags, input logic dma);
    return {dma, 2'b00, hflags, cmd, tx_empty, rx_full};
  endfunction

  function automatic logic [BYTE_W-1:0] host_status(
    input logic hrx_full, input logic htx_empty, input logic [1:0] dflags);
    return {3'b000, dflags, 1'b0, htx_empty, hrx_full};
  endfunction

  function automatic logic irq_need(
    input logic [BYTE_W-1:0] ctrl, input logic rx_full,
    input logic tx_empty, input logic cmd);
    return (ctrl[0] & rx_full) | (ctrl[1] & tx_empty) | (ctrl[2] & cmd);
  endfunction

  function automatic logic req_need(
    input logic [BYTE_W-1:0] ictl, input logic hrx_full, input logic htx_empty);
    return (ictl[0] & hrx_full) | (ictl[1] & htx_empty);
  endfunction
endpackage

// File: rtl/hb_host_sync.sv
module hb_host_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic en_n_async,
  output logic acc_start,
  output logic acc_end
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      last  <= 1'b1;
    end else if (soft_rst) begin
      chain <= '1;
      last  <= 1'b1;
    end else begin
      chain[0] <= en_n_async;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      last <= chain[STAGES-1];
    end
  end

  assign acc_start = last & ~chain[STAGES-1];
  assign acc_end   = ~last & chain[STAGES-1];
endmodule

// File: rtl/hb_xfer.sv
module hb_xfer
  import hb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              host_wr,
  input  logic [2:0]        h_addr,
  input  logic [BYTE_W-1:0] h_wdata,
  input  logic              host_rd_lo_end,
  input  logic              dsp_wr_data,
  input  logic              dsp_rd_data,
  input  logic [WORD_W-1:0] d_wdata,
  output logic [WORD_W-1:0] rx_word,
  output logic [WORD_W-1:0] hrx_word,
  output logic              rx_full,
  output logic              tx_empty,
  output logic              host_lo_try,
  output logic              host_commit,
  output logic              host_release,
  output logic              dsp_load
);
  logic [BYTE_W-1:0] stage_hi, stage_mid;

  assign host_lo_try  = host_wr && (h_addr == HA_LO);
  assign host_commit  = host_lo_try && !rx_full;
  assign host_release = host_rd_lo_end && !tx_empty;
  assign dsp_load     = dsp_wr_data && tx_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_hi <= '0; stage_mid <= '0; rx_word <= '0; hrx_word <= '0;
      rx_full <= 1'b0; tx_empty <= 1'b1;
    end else if (soft_rst) begin
      stage_hi <= '0; stage_mid <= '0; rx_word <= '0; hrx_word <= '0;
      rx_full <= 1'b0; tx_empty <= 1'b1;
    end else begin
      if (host_wr && h_addr == HA_HI)  stage_hi  <= h_wdata;
      if (host_wr && h_addr == HA_MID) stage_mid <= h_wdata;
      if (host_commit) begin
        rx_word <= join_bytes(stage_hi, stage_mid, h_wdata);
        rx_full <= 1'b1;
      end else if (dsp_rd_data) begin
        rx_full <= 1'b0;
      end
      if (dsp_load) begin
        hrx_word <= d_wdata;
        tx_empty <= 1'b0;
      end else if (host_release) begin
        tx_empty <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/hb_regs.sv
module hb_regs
  import hb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              host_wr,
  input  logic [2:0]        h_addr,
  input  logic [BYTE_W-1:0] h_wdata,
  input  logic              dsp_ctrl_wr,
  input  logic [4:0]        d_ctrl_in,
  output logic [BYTE_W-1:0] hcr,
  output logic [BYTE_W-1:0] icr,
  output logic [BYTE_W-1:0] cvr,
  output logic [BYTE_W-1:0] ivr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcr <= '0; icr <= '0; cvr <= '0; ivr <= '0;
    end else if (soft_rst) begin
      hcr <= '0; icr <= '0; cvr <= '0; ivr <= '0;
    end else begin
      if (dsp_ctrl_wr) hcr <= {3'b000, d_ctrl_in};
      if (host_wr) begin
        case (h_addr)
          HA_CTRL: icr <= h_wdata;
          HA_CMDV: cvr <= h_wdata;
          HA_VECT: ivr <= h_wdata;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/hb_bridge.sv
module hb_bridge
  import hb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              h_en_n,
  input  logic              h_rw,
  input  logic [2:0]        h_addr,
  input  logic [BYTE_W-1:0] h_wdata,
  output logic [BYTE_W-1:0] h_rdata,
  output logic              h_req,
  input  logic              d_sel,
  input  logic              d_we,
  input  logic [1:0]        d_addr,
  input  logic [WORD_W-1:0] d_wdata,
  output logic [WORD_W-1:0] d_rdata,
  output logic              d_irq
);
  logic acc_start, acc_end;
  logic [2:0] acc_addr;
  logic acc_read;
  logic host_wr, host_rd_lo_end;
  logic dsp_wr_data, dsp_rd_data, dsp_ctrl_wr;
  logic [WORD_W-1:0] rx_word, hrx_word;
  logic rx_full, tx_empty;
  logic host_lo_try, host_commit, host_release, dsp_load;
  logic [BYTE_W-1:0] hcr, icr, cvr, ivr;
  logic [BYTE_W-1:0] dstat, hstat;
  logic cmd_pend, dma_mode;

  hb_host_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .en_n_async(h_en_n),
    .acc_start(acc_start), .acc_end(acc_end));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_addr <= '0; acc_read <= 1'b0;
    end else if (soft_rst) begin
      acc_addr <= '0; acc_read <= 1'b0;
    end else if (acc_start) begin
      acc_addr <= h_addr; acc_read <= h_rw;
    end
  end

  assign host_wr        = acc_start && !h_rw;
  assign host_rd_lo_end = acc_end && acc_read && (acc_addr == HA_LO);
  assign dsp_wr_data    = d_sel && d_we && (d_addr == DA_DATA);
  assign dsp_rd_data    = d_sel && !d_we && (d_addr == DA_DATA);
  assign dsp_ctrl_wr    = d_sel && d_we && (d_addr == DA_CTRL);

  hb_xfer u_xfer (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .host_wr(host_wr),
    .h_addr(h_addr), .h_wdata(h_wdata), .host_rd_lo_end(host_rd_lo_end),
    .dsp_wr_data(dsp_wr_data), .dsp_rd_data(dsp_rd_data), .d_wdata(d_wdata),
    .rx_word(rx_word), .hrx_word(hrx_word), .rx_full(rx_full),
    .tx_empty(tx_empty), .host_lo_try(host_lo_try), .host_commit(host_commit),
    .host_release(host_release), .dsp_load(dsp_load));

  hb_regs u_regs (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .host_wr(host_wr),
    .h_addr(h_addr), .h_wdata(h_wdata), .dsp_ctrl_wr(dsp_ctrl_wr),
    .d_ctrl_in(d_wdata[4:0]), .hcr(hcr), .icr(icr), .cvr(cvr), .ivr(ivr));

  assign cmd_pend = cvr[7];
  assign dma_mode = |icr[6:5];
  assign dstat = dsp_status(rx_full, tx_empty, cmd_pend, icr[4:3], dma_mode);
  assign hstat = host_status(!tx_empty, !rx_full, hcr[4:3]);

  always_comb begin
    case (h_addr)
      HA_CTRL: h_rdata = icr;
      HA_CMDV: h_rdata = cvr;
      HA_STAT: h_rdata = hstat;
      HA_VECT: h_rdata = ivr;
      HA_HI:   h_rdata = pick_byte(hrx_word, 2'd0);
      HA_MID:  h_rdata = pick_byte(hrx_word, 2'd1);
      HA_LO:   h_rdata = pick_byte(hrx_word, 2'd2);
      default: h_rdata = '0;
    endcase
  end

  always_comb begin
    case (d_addr)
      DA_CTRL: d_rdata = {{(WORD_W-BYTE_W){1'b0}}, hcr};
      DA_STAT: d_rdata = {{(WORD_W-BYTE_W){1'b0}}, dstat};
      DA_DATA: d_rdata = rx_word;
      default: d_rdata = '0;
    endcase
  end

  assign d_irq = irq_need(hcr, rx_full, tx_empty, cmd_pend);
  assign h_req = req_need(icr, !tx_empty, !rx_full);
endmodule

// File: rtl/hb_bridge_chk.sv
module hb_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        soft_rst,
  input logic        host_lo_try,
  input logic        host_commit,
  input logic        host_release,
  input logic        dsp_load,
  input logic        dsp_wr_data,
  input logic        rx_full,
  input logic        tx_empty,
  input logic [23:0] rx_word,
  input logic [23:0] hrx_word,
  input logic [7:0]  hcr,
  input logic [7:0]  icr,
  input logic        d_irq,
  input logic        h_req
);
  // R2
  commit_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_commit && !soft_rst) |=> rx_full);
  // R4
  full_blocks_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_lo_try && rx_full && !soft_rst) |=> $stable(rx_word));
  // R5
  load_clears_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_load && !soft_rst) |=> !tx_empty);
  // R6
  release_sets_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_release && !soft_rst) |=> tx_empty);
  // R7
  busy_blocks_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_wr_data && !tx_empty && !soft_rst) |=> $stable(hrx_word));
  // R8
  irq_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && hcr[0]) |-> d_irq);
  // R10
  req_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_req |-> (icr[0] || icr[1]));
  // R11
  soft_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (tx_empty && !rx_full));
endmodule

bind hb_bridge hb_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .host_lo_try(host_lo_try),
  .host_commit(host_commit), .host_release(host_release), .dsp_load(dsp_load),
  .dsp_wr_data(dsp_wr_data), .rx_full(rx_full), .tx_empty(tx_empty),
  .rx_word(rx_word), .hrx_word(hrx_word), .hcr(hcr), .icr(icr),
  .d_irq(d_irq), .h_req(h_req));

// File: tb/test_hb_bridge.sv
module test_hb_bridge;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0;
  logic h_en_n = 1'b1, h_rw = 1'b1;
  logic [2:0] h_addr = '0;
  logic [7:0] h_wdata = '0, h_rdata;
  logic h_req;
  logic d_sel = 1'b0, d_we = 1'b0;
  logic [1:0] d_addr = '0;
  logic [23:0] d_wdata = '0, d_rdata;
  logic d_irq;
  int total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  hb_bridge i_hb_bridge (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .h_en_n(h_en_n),
    .h_rw(h_rw), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .h_req(h_req), .d_sel(d_sel), .d_we(d_we), .d_addr(d_addr),
    .d_wdata(d_wdata), .d_rdata(d_rdata), .d_irq(d_irq));

  // bench model of the status words, built bit by bit
  function automatic logic [7:0] m_dstat(bit rxf, bit txe, bit cmd, bit [1:0] hf, bit dma);
    logic [7:0] v = 8'h00;
    if (rxf) v = v + 8'd1;
    if (txe) v = v + 8'd2;
    if (cmd) v = v + 8'd4;
    v = v + 8'(hf) * 8'd8;
    if (dma) v = v + 8'd128;
    return v;
  endfunction

  function automatic logic [7:0] m_hstat(bit hrxf, bit htxe, bit [1:0] df);
    return 8'(hrxf) + 8'(htxe) * 8'd2 + 8'(df) * 8'd8;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    h_addr = a; h_wdata = d; h_rw = 1'b0; h_en_n = 1'b0;
    repeat (5) @(negedge clk);
    h_en_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic host_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    h_addr = a; h_rw = 1'b1; h_en_n = 1'b0;
    repeat (4) @(negedge clk);
    d = h_rdata;
    @(negedge clk);
    h_en_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic dsp_write(input logic [1:0] a, input logic [23:0] d);
    @(negedge clk);
    d_sel = 1'b1; d_we = 1'b1; d_addr = a; d_wdata = d;
    @(negedge clk);
    d_sel = 1'b0; d_we = 1'b0;
  endtask

  task automatic dsp_read(input logic [1:0] a, output logic [23:0] d);
    @(negedge clk);
    d_sel = 1'b1; d_we = 1'b0; d_addr = a;
    #1 d = d_rdata;
    @(negedge clk);
    d_sel = 1'b0;
  endtask

  task automatic dsp_peek(input logic [1:0] a, output logic [23:0] d);
    @(negedge clk);
    d_addr = a;
    #1 d = d_rdata;
  endtask

  task automatic host_send(input logic [23:0] w);
    host_write(3'd5, w[23:16]);
    host_write(3'd6, w[15:8]);
    host_write(3'd7, w[7:0]);
  endtask

  task automatic host_fetch(output logic [23:0] w);
    logic [7:0] b;
    host_read(3'd5, b); w[23:16] = b;
    host_read(3'd6, b); w[15:8] = b;
    host_read(3'd7, b); w[7:0] = b;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [23:0] w, r;
    logic [7:0] b;
    int unsigned seed;
    seed = $urandom(32'd4242);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    dsp_peek(2'd1, r); check(r == 24'(m_dstat(0,1,0,2'b00,0)), "R1 dsp status", r, 2);
    dsp_peek(2'd0, r); check(r == 0, "R1 dsp control", r, 0);
    host_read(3'd2, b); check(b == m_hstat(0,1,2'b00), "R1 host status", b, 2);
    check(d_irq == 0 && h_req == 0, "R1 irq/req low", {d_irq,h_req}, 0);

    // R12 host register readback
    host_write(3'd1, 8'h5A); host_read(3'd1, b); check(b == 8'h5A, "R12 cmd vector", b, 8'h5A);
    host_write(3'd3, 8'h3C); host_read(3'd3, b); check(b == 8'h3C, "R12 int vector", b, 8'h3C);
    host_write(3'd2, 8'hFF); host_read(3'd2, b); check(b == 8'h02, "R12 status read-only", b, 2);
    host_read(3'd4, b); check(b == 8'h00, "R12 gap address", b, 0);

    // R9 flags and mirrors
    dsp_write(2'd0, 24'h18); host_read(3'd2, b);
    check(b == m_hstat(0,1,2'b11), "R9 dsp flags to host", b, m_hstat(0,1,2'b11));
    host_write(3'd0, 8'h08); dsp_peek(2'd1, r);
    check(r == 24'(m_dstat(0,1,0,2'b01,0)), "R9 host flag to dsp", r, m_dstat(0,1,0,2'b01,0));
    host_write(3'd0, 8'h40); host_write(3'd1, 8'h80); dsp_peek(2'd1, r);
    check(r == 24'(m_dstat(0,1,1,2'b00,1)), "R9 cmd and mode bits", r, m_dstat(0,1,1,2'b00,1));
    // R8 command interrupt path
    dsp_write(2'd0, 24'h04); @(negedge clk);
    check(d_irq == 1, "R8 cmd irq", d_irq, 1);
    host_write(3'd1, 8'h00); host_write(3'd0, 8'h00); dsp_write(2'd0, 24'h00);

    // R2 / R3 host to dsp
    host_send(24'hA1B2C3); dsp_peek(2'd1, r);
    check(r[0] == 1, "R2 receive full set", r[0], 1);
    dsp_read(2'd3, r); check(r == 24'hA1B2C3, "R2 word assembled", r, 24'hA1B2C3);
    dsp_peek(2'd1, r); check(r[0] == 0, "R3 receive full cleared", r[0], 0);
    host_read(3'd2, b); check(b[1] == 1, "R3 host tx empty", b[1], 1);

    // R4 blocked overwrite
    host_send(24'h112233); host_send(24'h445566);
    dsp_read(2'd3, r); check(r == 24'h112233, "R4 overwrite ignored", r, 24'h112233);

    // R5 / R6 dsp to host
    dsp_write(2'd3, 24'hDEAD01); host_read(3'd2, b);
    check(b[0] == 1, "R5 host rx full", b[0], 1);
    dsp_peek(2'd1, r); check(r[1] == 0, "R5 tx empty cleared", r[1], 0);
    host_read(3'd5, b); check(b == 8'hDE, "R5 high byte", b, 8'hDE);
    host_read(3'd6, b); check(b == 8'hAD, "R5 middle byte", b, 8'hAD);
    dsp_peek(2'd1, r); check(r[1] == 0, "R6 no release before low", r[1], 0);
    host_read(3'd7, b); check(b == 8'h01, "R5 low byte", b, 8'h01);
    dsp_peek(2'd1, r); check(r[1] == 1, "R6 low read releases", r[1], 1);

    // R7 blocked dsp overwrite
    dsp_write(2'd3, 24'h0F0E0D); dsp_write(2'd3, 24'h777777);
    host_fetch(w); check(w == 24'h0F0E0D, "R7 second write ignored", w, 24'h0F0E0D);

    // R8 / R10 interrupt and request
    host_send(24'h000001);
    dsp_write(2'd0, 24'h01); @(negedge clk); check(d_irq == 1, "R8 rx irq", d_irq, 1);
    dsp_write(2'd0, 24'h02); @(negedge clk); check(d_irq == 1, "R8 tx irq", d_irq, 1);
    dsp_write(2'd3, 24'h123456);
    @(negedge clk); check(d_irq == 0, "R8 tx irq drops", d_irq, 0);
    host_write(3'd0, 8'h01); check(h_req == 1, "R10 rx request", h_req, 1);
    host_write(3'd0, 8'h02); check(h_req == 0, "R10 tx request off when full", h_req, 0);

    // R11 soft reset
    @(negedge clk); soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0;
    dsp_peek(2'd1, r); check(r == 24'h02, "R11 status restored", r, 2);
    dsp_peek(2'd0, r); check(r == 0, "R11 control cleared", r, 0);
    host_read(3'd0, b); check(b == 0, "R11 host control cleared", b, 0);
    check(d_irq == 0 && h_req == 0, "R11 outputs low", {d_irq,h_req}, 0);

    // random handoffs, both directions (R2 R5)
    for (int i = 0; i < 40; i++) begin
      w = 24'($urandom);
      if ($urandom % 2) begin
        host_send(w); dsp_read(2'd3, r);
        check(r == w, "R2 random host to dsp", r, w);
      end else begin
        dsp_write(2'd3, w); host_fetch(r);
        check(r == w, "R5 random dsp to host", r, w);
      end
    end
    dsp_peek(2'd1, r); check(r == 24'h02, "R6 idle after random", r, 2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule